// File: doc/BRIEF.md
# Card Socket Interrupt Router

This block takes the interrupt requests of two card sockets and places them on the system's interrupt pins. Each socket raises two kinds of request: a status-change request and a functional request. That makes four sources in all. Software sets a small group of write-only registers. These registers choose the signalling style and, for each source, where its request goes.

In legacy ISA style, each source carries a 4-bit IRQ number. Only ten IRQ numbers have a pin: 3, 4, 5, 7, 9, 10, 11, 12, 14 and 15. A pin is driven actively, high for asserted, once at least one source selects it. Until then it stays released. In PCI style, each socket owns one open-drain line. Socket A uses INTA and socket B uses INTB. Per-class enable bits pick which requests may pull the line low, and a global enable gates all PCI routing. The INTA and INTB lines share the IRQ3 and IRQ4 pins, so those pins change role in PCI style. The two styles can run together.

All outputs are registered, so an input change shows at the pins one clock later. Each IRQ number 0 to 15 has one bit in `irq_o` and one bit in `irq_oe`. Bits with no pin are never driven.

Top module: `card_irq_router`

## Requirements
- R1: While `rst_n` is low and after reset, all routing numbers, enables and the mode are zero. Every `irq_oe` bit, `inta_oe` and `intb_oe` is 0.
- R2: Write address 0 sets the mode (`wr_data[1:0]`). Addresses 1 and 3 set the functional IRQ number of socket A and socket B from `wr_data[3:0]`. Addresses 2 and 4 set their status-change IRQ number from `wr_data[7:4]`. With mode 01, a source whose number is legal drives `irq_oe[n]`=1. The line `irq_o[n]` then follows that source's request.
- R3: IRQ numbers 0, 1, 2, 6, 8 and 13 drive no pin. An undriven pin always shows `irq_o`=0 and `irq_oe`=0.
- R4: When several sources select the same IRQ number, that pin shows the OR of their requests. It stays driven low while none of them is asserted.
- R5: ISA routing works only when mode bit 0 is 1 (modes 01 and 11). In modes 00 and 10, no pin is driven by ISA routing.
- R6: PCI routing is on when mode bit 1 is 1 and the global enable (`wr_data[2]` at address 0) is 1. Then `inta_oe` is 1 while an enabled socket A request is high, and `intb_oe` does the same for socket B. Each socket drives only its own line.
- R7: Address 5 holds the socket A PCI enables and address 6 those of socket B. Bit 0 enables status-change requests and bit 1 enables functional requests. A request whose class is disabled does not reach INTx.
- R8: With the global enable at 0, `inta_oe` and `intb_oe` stay 0 whatever the mode and enables are.
- R9: While PCI routing is on, pins 3 and 4 carry INTA and INTB. `irq_o`=0 and `irq_oe` equals `inta_oe` or `intb_oe`. ISA routing to IRQ 3 or 4 is ignored, and the other ISA pins keep working.
- R10: A change on a request input or a completed register write shows at the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| csc_req | input | 2 | Status-change request per socket (bit 0 = A) |
| fun_req | input | 2 | Functional request per socket (bit 0 = A) |
| irq_o | output | 16 | Pin value per IRQ number |
| irq_oe | output | 16 | Pin output enable per IRQ number |
| inta_oe | output | 1 | INTA pulled low when 1 |
| intb_oe | output | 1 | INTB pulled low when 1 |

## Verification
The hardest case to reach is the combined mode. In it, the PCI lines take over pins 3 and 4 while an ISA route still points at IRQ 3, and another pin is shared by both sockets. The stimulus first builds that routing in ISA-only mode. It then turns on PCI with the global bit and asserts both classes of socket A. Finally it drops back to ISA-only mode, so the same route visibly drives pin 3 again. A sweep of all sixteen routing numbers covers the legal and illegal values.

// File: rtl/card_irq_router.sv
module card_irq_router #(
  parameter int          NUM_IRQ    = 16,
  parameter int          ROUTE_W    = 4,
  parameter int          PIN_A      = 3,
  parameter int          PIN_B      = 4,
  parameter logic [15:0] LEGAL_MASK = 16'hDEB8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [1:0]         csc_req,
  input  logic [1:0]         fun_req,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic [NUM_IRQ-1:0] irq_oe,
  output logic               inta_oe,
  output logic               intb_oe
);
  localparam int NSRC = 4;

  logic [1:0]         mode_q;
  logic               glob_q;
  logic [ROUTE_W-1:0] route_q [NSRC];
  logic [1:0]         en_a_q, en_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      glob_q <= 1'b0;
      en_a_q <= '0;
      en_b_q <= '0;
      for (int s = 0; s < NSRC; s++) route_q[s] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin mode_q <= wr_data[1:0]; glob_q <= wr_data[2]; end
        3'd1: route_q[1] <= wr_data[3:0];
        3'd2: route_q[0] <= wr_data[7:4];
        3'd3: route_q[3] <= wr_data[3:0];
        3'd4: route_q[2] <= wr_data[7:4];
        3'd5: en_a_q <= wr_data[1:0];
        3'd6: en_b_q <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  wire             isa_on = mode_q[0];
  wire             pci_on = mode_q[1] & glob_q;
  wire [NSRC-1:0]  req_v  = {fun_req[1], csc_req[1], fun_req[0], csc_req[0]};
  wire             int_a  = pci_on & ((csc_req[0] & en_a_q[0]) | (fun_req[0] & en_a_q[1]));
  wire             int_b  = pci_on & ((csc_req[1] & en_b_q[0]) | (fun_req[1] & en_b_q[1]));

  logic [NUM_IRQ-1:0] isa_val, isa_oe;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    logic [NSRC-1:0] sel;
    always_comb
      for (int s = 0; s < NSRC; s++) sel[s] = (route_q[s] == ROUTE_W'(k));
    wire shared = (k == PIN_A || k == PIN_B) && pci_on;
    assign isa_oe[k]  = LEGAL_MASK[k] & isa_on & (|sel) & ~shared;
    assign isa_val[k] = isa_oe[k] & (|(sel & req_v));
  end

  logic [NUM_IRQ-1:0] nxt_o, nxt_oe;
  always_comb begin
    nxt_o  = isa_val;
    nxt_oe = isa_oe;
    if (pci_on) begin
      nxt_o[PIN_A]  = 1'b0;
      nxt_oe[PIN_A] = int_a;
      nxt_o[PIN_B]  = 1'b0;
      nxt_oe[PIN_B] = int_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o   <= '0;
      irq_oe  <= '0;
      inta_oe <= 1'b0;
      intb_oe <= 1'b0;
    end else begin
      irq_o   <= nxt_o;
      irq_oe  <= nxt_oe;
      inta_oe <= int_a;
      intb_oe <= int_b;
    end
  end
endmodule

// File: rtl/card_irq_router_chk.sv
module card_irq_router_chk #(
  parameter logic [15:0] LEGAL_MASK = 16'hDEB8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  csc_req,
  input logic [1:0]  fun_req,
  input logic [15:0] irq_o,
  input logic [15:0] irq_oe,
  input logic        inta_oe,
  input logic        intb_oe,
  input logic [1:0]  mode_q,
  input logic        glob_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_oe == 16'h0 && !inta_oe && !intb_oe));

  a_r3_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe & ~LEGAL_MASK) == 16'h0);

  a_r3_value_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~irq_oe) == 16'h0);

  a_r5_isa_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q[0] == 1'b0) |-> (irq_oe & ~16'h0018) == 16'h0);

  a_r6_inta_cause: assert property (@(posedge clk) disable iff (!rst_n)
    inta_oe |-> $past(csc_req[0] | fun_req[0]));

  a_r6_intb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    intb_oe |-> $past(csc_req[1] | fun_req[1]));

  a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!glob_q) |-> (!inta_oe && !intb_oe));

  a_r9_pin_a: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q[1] & glob_q) |-> (irq_oe[3] == inta_oe && !irq_o[3]));

  a_r9_pin_b: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q[1] & glob_q) |-> (irq_oe[4] == intb_oe && !irq_o[4]));
endmodule

bind card_irq_router card_irq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csc_req(csc_req), .fun_req(fun_req),
  .irq_o(irq_o), .irq_oe(irq_oe), .inta_oe(inta_oe), .intb_oe(intb_oe),
  .mode_q(mode_q), .glob_q(glob_q)
);

// File: tb/card_irq_router_test.sv
module card_irq_router_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [1:0]  csc_req = 0;
  logic [1:0]  fun_req = 0;
  logic [15:0] irq_o, irq_oe;
  logic        inta_oe, intb_oe;

  card_irq_router uut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [15:0] o;
    logic [15:0] oe;
    logic        a;
    logic        b;
    int          due;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  logic [1:0] m_mode = 0;
  logic       m_glob = 0;
  logic [3:0] m_rt [4] = '{default: 0};
  logic [1:0] m_ena = 0, m_enb = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit legal(input logic [3:0] n);
    return n == 3 || n == 4 || n == 5 || n == 7 || n == 9 ||
           n == 10 || n == 11 || n == 12 || n == 14 || n == 15;
  endfunction

  function automatic exp_t model(input logic [1:0] c, input logic [1:0] f);
    exp_t e;
    logic [3:0] rq;
    bit pci;
    e.o = 0; e.oe = 0;
    rq = {f[1], c[1], f[0], c[0]};
    pci = m_mode[1] && m_glob;
    e.a = pci && ((c[0] && m_ena[0]) || (f[0] && m_ena[1]));
    e.b = pci && ((c[1] && m_enb[0]) || (f[1] && m_enb[1]));
    if (m_mode[0])
      for (int s = 0; s < 4; s++)
        if (legal(m_rt[s]) && !(pci && (m_rt[s] == 3 || m_rt[s] == 4))) begin
          e.oe[m_rt[s]] = 1;
          if (rq[s]) e.o[m_rt[s]] = 1;
        end
    if (pci) begin
      e.o[3] = 0; e.oe[3] = e.a;
      e.o[4] = 0; e.oe[4] = e.b;
    end
    return e;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    case (a)
      3'd0: begin m_mode = d[1:0]; m_glob = d[2]; end
      3'd1: m_rt[1] = d[3:0];
      3'd2: m_rt[0] = d[7:4];
      3'd3: m_rt[3] = d[3:0];
      3'd4: m_rt[2] = d[7:4];
      3'd5: m_ena = d[1:0];
      3'd6: m_enb = d[1:0];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] f, input string tag);
    exp_t e;
    @(negedge clk);
    csc_req = c; fun_req = f;
    e = model(c, f);
    e.due = cyc + 1;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (irq_o !== e.o || irq_oe !== e.oe || inta_oe !== e.a || intb_oe !== e.b) begin
        bad++;
        $display("FAIL %s: got o=%h oe=%h a=%b b=%b exp o=%h oe=%h a=%b b=%b",
                 e.tag, irq_o, irq_oe, inta_oe, intb_oe, e.o, e.oe, e.a, e.b);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    csc_req = 2'b11; fun_req = 2'b11;
    repeat (3) @(negedge clk);
    total++;
    if (irq_oe !== 0 || inta_oe !== 0 || intb_oe !== 0) begin
      bad++;
      $display("FAIL R1 reset: got oe=%h a=%b b=%b exp 0", irq_oe, inta_oe, intb_oe);
    end
    rst_n = 1;
    step(2'b11, 2'b11, "R1 after reset idle");
    step(2'b11, 2'b11, "R5 mode 00 no drive");

    wr(0, 8'h01);
    wr(2, 8'h50);
    wr(1, 8'h09);
    step(2'b01, 2'b00, "R2 csc A on irq5");
    step(2'b00, 2'b01, "R2 fun A on irq9");
    step(2'b00, 2'b00, "R10 pulse released");

    wr(4, 8'h20);
    wr(3, 8'h0D);
    step(2'b10, 2'b10, "R3 socket B illegal numbers");

    for (int v = 0; v < 16; v++) begin
      wr(2, 8'(v << 4));
      step(2'b01, 2'b00, $sformatf("R3 sweep csc A number %0d", v));
    end
    wr(2, 8'h50);

    wr(4, 8'h50);
    step(2'b10, 2'b00, "R4 shared irq5 from B");
    step(2'b00, 2'b00, "R4 shared irq5 idle");
    step(2'b11, 2'b00, "R4 shared irq5 both");

    wr(5, 8'h03);
    wr(6, 8'h03);
    wr(0, 8'h02);
    step(2'b11, 2'b11, "R8 global off");
    step(2'b11, 2'b11, "R5 mode 10 no isa");

    wr(0, 8'h06);
    step(2'b01, 2'b00, "R6 socket A to INTA");
    step(2'b10, 2'b00, "R6 socket B to INTB");
    step(2'b00, 2'b00, "R6 lines released");

    wr(5, 8'h01);
    step(2'b00, 2'b01, "R7 A fun disabled");
    step(2'b01, 2'b00, "R7 A csc enabled");
    wr(6, 8'h02);
    step(2'b10, 2'b00, "R7 B csc disabled");
    step(2'b00, 2'b10, "R7 B fun enabled");

    wr(1, 8'h03);
    wr(0, 8'h07);
    step(2'b01, 2'b01, "R9 combined pin3 INTA irq5 isa");
    step(2'b00, 2'b01, "R9 combined isa route to 3 ignored");
    wr(0, 8'h03);
    step(2'b00, 2'b01, "R8 combined global off isa on pin3");
    wr(0, 8'h01);
    step(2'b00, 2'b01, "R9 isa only drives pin3");

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule